// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block arbitrates the interrupt requests of a small CPU. Each maskable source has a control register with a pending flag, a mask flag and a 3-bit priority level. A peripheral event sets the pending flag, and the flag is cleared by hardware when the CPU takes the interrupt. One further input is non-maskable. The CPU side supplies three one-cycle strobes: enable, disable and return-from-interrupt. When a request is granted, the controller offers the handler vector on a valid/ready channel.

An eligible request is offered only after a fixed detection window has run. The window starts again when the eligible set goes from empty to non-empty, and also on every enable strobe. When the CPU accepts the offer, the block sets the disable flag, records the level in a per-level in-service register and clears the source's pending flag. That clear wins over a software write to the same register in the same cycle. A request nests only above a strictly more urgent level. The return strobe retires the most urgent in-service level, or the non-maskable service if one is active, and restores the enable state that was saved when that interrupt was accepted.

Vector channel rules: once `ack_valid` rises, it stays high and `ack_vector` holds its value until a cycle with `ack_ready` high. No new arbitration takes place while an offer is outstanding.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset the control registers read 0x47: pending 0 (bit 7), masked 1 (bit 6), bits 5:3 zero, priority 7 (bits 2:0). The disable flag is 1, no offer is made, the in-service register is 0 and the non-maskable flag is 0.
- R2: With interrupts enabled, a request becomes eligible in the cycle after its pending flag is set. `ack_valid` rises exactly DETECT_CYC (7) clock edges after that.
- R3: An enable strobe restarts the window, so an offer comes DETECT_CYC edges after the enable. A disable strobe inside the window cancels the offer, and the pending flag stays set.
- R4: Acceptance (valid and ready in the same cycle) sets the disable flag, sets in-service bit [priority] and clears the source's pending flag.
- R5: The non-maskable vector is 0x10. Maskable source i has vector 0x80 + 0x10*i.
- R6: A pending non-maskable request wins over every maskable one. Among maskable requests the lowest priority number wins, and a tie goes to the lower source index.
- R7: While level L is the most urgent in-service level, only requests with priority strictly below L are eligible.
- R8: The non-maskable request is offered even while interrupts are disabled. Its acceptance sets the non-maskable flag, and while that flag is set no request of any kind is offered.
- R9: A software write in the acceptance cycle to the register of the accepted source updates the mask and priority fields, but the pending flag ends up 0, so the interrupt is not offered a second time.
- R10: A return strobe clears the non-maskable flag if it is set. Otherwise it clears the lowest-numbered in-service bit. In both cases it restores the disable flag saved when that interrupt was accepted.
- R11: A masked source with its pending flag set is never offered.
- R12: While `ack_valid` is high and `ack_ready` is low, `ack_valid` stays high and `ack_vector` is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Per-source event pulse that sets the pending flag |
| nmi_evt | input | 1 | Non-maskable event pulse |
| sw_wr | input | 1 | Software write strobe for a control register |
| sw_sel | input | SEL_W | Source index for write and read |
| sw_wdata | input | 8 | Write data: bit 7 pending, bit 6 mask, bits 2:0 priority |
| sw_rdata | output | 8 | Selected control register, same layout |
| ei_strobe | input | 1 | Global enable |
| di_strobe | input | 1 | Global disable |
| reti_strobe | input | 1 | Return from interrupt |
| ack_valid | output | 1 | Vector offer valid |
| ack_ready | input | 1 | CPU takes the offer |
| ack_vector | output | VEC_W | Handler address |
| int_disabled | output | 1 | Interrupt-disable flag |
| nmi_active | output | 1 | Non-maskable service in progress |
| in_service | output | 8 | One bit per priority level in service |

## Verification
Errors in the internal state show up at the vector channel within one detection window. If the in-service register, the saved enable flag or the non-maskable flag is wrong, the bench sees either a vector where it expected none, a vector missing where it expected one, or a vector in the wrong order. It counts the edges to each offer, so a detection counter that is off by one gives a latency of 7 or 9 instead of 8 at the first offer. A pending flag that survives acceptance leads to a second identical vector about 8 cycles after the return, and the scoreboard has no entry for it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned PRIO_W   = 3;
  localparam int unsigned LEVELS   = 1 << PRIO_W;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned REQ_BIT  = 7;
  localparam int unsigned MASK_BIT = 6;

  localparam logic [15:0] NMI_VEC       = 16'h0010;
  localparam logic [15:0] MASK_VEC_BASE = 16'h0080;
  localparam logic [15:0] MASK_VEC_STEP = 16'h0010;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic  req;
    logic  mask;
    prio_t prio;
  } src_ctrl_t;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_pkg::*;
#(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         evt,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [CTRL_W-1:0]       wr_data,
  input  logic                    clr_en,
  input  logic [SEL_W-1:0]        clr_sel,
  output src_ctrl_t [NSRC-1:0]    ctrl
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic wr_hit;
    logic clr_hit;
    assign wr_hit  = wr_en  && (wr_sel  == SEL_W'(i));
    assign clr_hit = clr_en && (clr_sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl[i].req  <= 1'b0;
        ctrl[i].mask <= 1'b1;
        ctrl[i].prio <= '1;
      end else begin
        if (wr_hit) begin
          ctrl[i].mask <= wr_data[MASK_BIT];
          ctrl[i].prio <= wr_data[PRIO_W-1:0];
        end
        // a new event wins; the hardware clear beats a software rewrite
        if (evt[i])       ctrl[i].req <= 1'b1;
        else if (clr_hit) ctrl[i].req <= 1'b0;
        else if (wr_hit)  ctrl[i].req <= wr_data[REQ_BIT];
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_pkg::*;
#(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [NSRC-1:0]      cand,
  input  src_ctrl_t [NSRC-1:0] ctrl,
  output logic                 any,
  output logic [SEL_W-1:0]     win_idx,
  output prio_t                win_prio
);
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!any || ctrl[i].prio < win_prio)) begin
        any      = 1'b1;
        win_idx  = SEL_W'(i);
        win_prio = ctrl[i].prio;
      end
    end
  end
endmodule

// File: rtl/irq_detect_win.sv
module irq_detect_win #(
  parameter int unsigned DETECT_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic fire
);
  localparam int unsigned CNT_W = $clog2(DETECT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DETECT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign fire = active && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !active || restart) cnt_q <= '0;
    else if (cnt_q != LAST)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_svc_state.sv
module irq_svc_state
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ei,
  input  logic              di,
  input  logic              reti,
  input  logic              acc_mask,
  input  logic              acc_nmi,
  input  prio_t             acc_prio,
  output logic              id,
  output logic              np,
  output logic [LEVELS-1:0] isr,
  output logic [PRIO_W:0]   top_level
);
  logic [LEVELS-1:0] saved_id;
  logic              nmi_saved_id;
  logic              busy;

  always_comb begin
    top_level = (PRIO_W+1)'(LEVELS);
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (isr[l]) top_level = (PRIO_W+1)'(l);
    end
  end

  assign busy = (isr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id           <= 1'b1;
      np           <= 1'b0;
      isr          <= '0;
      saved_id     <= '0;
      nmi_saved_id <= 1'b0;
    end else if (acc_nmi) begin
      np           <= 1'b1;
      id           <= 1'b1;
      nmi_saved_id <= id;
    end else if (acc_mask) begin
      id                 <= 1'b1;
      isr[acc_prio]      <= 1'b1;
      saved_id[acc_prio] <= id;
    end else if (reti) begin
      if (np) begin
        np <= 1'b0;
        id <= nmi_saved_id;
      end else if (busy) begin
        isr[top_level[PRIO_W-1:0]] <= 1'b0;
        id <= saved_id[top_level[PRIO_W-1:0]];
      end
    end else if (di) begin
      id <= 1'b1;
    end else if (ei) begin
      id <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NSRC       = 4,
  parameter int unsigned DETECT_CYC = 7,
  parameter int unsigned VEC_W      = 16,
  localparam int unsigned SEL_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_evt,
  input  logic               nmi_evt,
  input  logic               sw_wr,
  input  logic [SEL_W-1:0]   sw_sel,
  input  logic [7:0]         sw_wdata,
  output logic [7:0]         sw_rdata,
  input  logic               ei_strobe,
  input  logic               di_strobe,
  input  logic               reti_strobe,
  output logic               ack_valid,
  input  logic               ack_ready,
  output logic [VEC_W-1:0]   ack_vector,
  output logic               int_disabled,
  output logic               nmi_active,
  output logic [7:0]         in_service
);
  src_ctrl_t [NSRC-1:0] ctrl;
  logic [NSRC-1:0]      cand;
  logic                 arb_any;
  logic [SEL_W-1:0]     win_idx;
  prio_t                win_prio;
  logic                 id, np;
  logic [LEVELS-1:0]    isr;
  logic [PRIO_W:0]      top_level;
  logic                 nmi_pend_q;
  logic                 nmi_cand;
  logic                 active, fire;
  logic                 offer_q, sel_nmi_q;
  logic [SEL_W-1:0]     sel_idx_q;
  prio_t                sel_prio_q;
  logic [VEC_W-1:0]     vec_q;
  logic                 accept, acc_nmi, acc_mask;

  assign accept   = offer_q && ack_ready;
  assign acc_nmi  = accept && sel_nmi_q;
  assign acc_mask = accept && !sel_nmi_q;

  irq_src_regs #(.NSRC(NSRC), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt(src_evt),
    .wr_en(sw_wr), .wr_sel(sw_sel), .wr_data(sw_wdata),
    .clr_en(acc_mask), .clr_sel(sel_idx_q), .ctrl(ctrl)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_cand
    assign cand[i] = ctrl[i].req && !ctrl[i].mask &&
                     ({1'b0, ctrl[i].prio} < top_level) &&
                     !id && !np && !offer_q;
  end

  assign nmi_cand = nmi_pend_q && !np && !offer_q;
  assign active   = arb_any || nmi_cand;

  irq_prio_arb #(.NSRC(NSRC), .SEL_W(SEL_W)) u_arb (
    .cand(cand), .ctrl(ctrl), .any(arb_any),
    .win_idx(win_idx), .win_prio(win_prio)
  );

  irq_detect_win #(.DETECT_CYC(DETECT_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(ei_strobe),
    .active(active), .fire(fire)
  );

  irq_svc_state u_svc (
    .clk(clk), .rst_n(rst_n), .ei(ei_strobe), .di(di_strobe),
    .reti(reti_strobe), .acc_mask(acc_mask), .acc_nmi(acc_nmi),
    .acc_prio(sel_prio_q), .id(id), .np(np), .isr(isr),
    .top_level(top_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_pend_q <= 1'b0;
    end else if (nmi_evt) begin
      nmi_pend_q <= 1'b1;
    end else if (acc_nmi) begin
      nmi_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_q    <= 1'b0;
      sel_nmi_q  <= 1'b0;
      sel_idx_q  <= '0;
      sel_prio_q <= '0;
      vec_q      <= '0;
    end else if (fire) begin
      offer_q    <= 1'b1;
      sel_nmi_q  <= nmi_cand;
      sel_idx_q  <= win_idx;
      sel_prio_q <= win_prio;
      vec_q      <= nmi_cand ? VEC_W'(NMI_VEC)
                             : VEC_W'(MASK_VEC_BASE + MASK_VEC_STEP * 16'(win_idx));
    end else if (accept) begin
      offer_q <= 1'b0;
    end
  end

  always_comb begin
    sw_rdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sw_sel == SEL_W'(i)) begin
        sw_rdata[REQ_BIT]      = ctrl[i].req;
        sw_rdata[MASK_BIT]     = ctrl[i].mask;
        sw_rdata[PRIO_W-1:0]   = ctrl[i].prio;
      end
    end
  end

  assign ack_valid    = offer_q;
  assign ack_vector   = vec_q;
  assign int_disabled = id;
  assign nmi_active   = np;
  assign in_service   = 8'(isr);
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ei_strobe,
  input logic             reti_strobe,
  input logic             ack_valid,
  input logic             ack_ready,
  input logic [VEC_W-1:0] ack_vector,
  input logic             int_disabled,
  input logic             nmi_active,
  input logic [7:0]       in_service
);
  logic is_nmi_vec;
  assign is_nmi_vec = (ack_vector == VEC_W'(NMI_VEC));

  assert_offer_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !ack_ready |=> ack_valid && $stable(ack_vector));

  assert_accept_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready |=> int_disabled);

  assert_nmi_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready && is_nmi_vec |=> nmi_active);

  assert_hold_in_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_valid) |-> !$past(nmi_active));

  assert_enable_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_valid) && !is_nmi_vec |-> !$past(int_disabled) && !$past(ei_strobe));

  assert_reti_retires_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reti_strobe && !nmi_active && (in_service != 8'h00) && !(ack_valid && ack_ready)
    |=> $countones(in_service) == $countones($past(in_service)) - 1);
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ei_strobe(ei_strobe), .reti_strobe(reti_strobe),
  .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_vector(ack_vector),
  .int_disabled(int_disabled), .nmi_active(nmi_active), .in_service(in_service)
);

// File: tb/tb_irq_ack_ctrl.sv
`timescale 1ns/100ps
module tb_irq_ack_ctrl;
  localparam int NSRC = 4;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_evt = '0;
  logic        nmi_evt = 1'b0;
  logic        sw_wr = 1'b0;
  logic [1:0]  sw_sel = '0;
  logic [7:0]  sw_wdata = '0;
  logic [7:0]  sw_rdata;
  logic        ei_strobe = 1'b0, di_strobe = 1'b0, reti_strobe = 1'b0;
  logic        ack_valid;
  logic        ack_ready = 1'b0;
  logic [15:0] ack_vector;
  logic        int_disabled, nmi_active;
  logic [7:0]  in_service;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  bit done = 0;

  always #(HALF) clk = ~clk;

  irq_ack_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .nmi_evt(nmi_evt),
    .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .ei_strobe(ei_strobe), .di_strobe(di_strobe), .reti_strobe(reti_strobe),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_vector(ack_vector),
    .int_disabled(int_disabled), .nmi_active(nmi_active), .in_service(in_service)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected vector at every acceptance
  always @(negedge clk) begin
    #2;
    if (ack_valid && ack_ready) begin
      if (exp_q.size() == 0) chk("R9 unexpected vector", int'(ack_vector), 0);
      else chk("R5 scoreboard vector", int'(ack_vector), int'(exp_q.pop_front()));
    end
  end

  task automatic push_exp(logic [15:0] v);
    exp_q.push_back(v);
  endtask

  task automatic pulse_src(logic [3:0] m);
    src_evt = m; @(negedge clk); src_evt = '0;
  endtask
  task automatic pulse_nmi();
    nmi_evt = 1'b1; @(negedge clk); nmi_evt = 1'b0;
  endtask
  task automatic pulse_ei();
    ei_strobe = 1'b1; @(negedge clk); ei_strobe = 1'b0;
  endtask
  task automatic pulse_di();
    di_strobe = 1'b1; @(negedge clk); di_strobe = 1'b0;
  endtask
  task automatic pulse_reti();
    reti_strobe = 1'b1; @(negedge clk); reti_strobe = 1'b0;
  endtask
  task automatic wr_ctrl(int sel, logic [7:0] d);
    sw_sel = 2'(sel); sw_wdata = d; sw_wr = 1'b1; @(negedge clk); sw_wr = 1'b0;
  endtask
  task automatic rd_ctrl(int sel, output logic [7:0] d);
    sw_sel = 2'(sel); #1; d = sw_rdata;
  endtask

  task automatic wait_offer(output int n);
    n = 1;
    while (!ack_valid && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic quiet(int cycles, string req);
    bit seen = 0;
    repeat (cycles) begin @(negedge clk); if (ack_valid) seen = 1; end
    chk(req, int'(seen), 0);
  endtask

  task automatic accept();
    #1 ack_ready = 1'b1;
    @(posedge clk); #1 ack_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic accept_wr(int sel, logic [7:0] d);
    sw_sel = 2'(sel); sw_wdata = d; sw_wr = 1'b1;
    #1 ack_ready = 1'b1;
    @(posedge clk); #1 ack_ready = 1'b0; sw_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic offer_and_take(string req, int exp_lat, logic [15:0] v);
    int n;
    wait_offer(n);
    chk({req, " latency"}, n, exp_lat);
    chk({req, " vector"}, int'(ack_vector), int'(v));
    push_exp(v);
    accept();
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ack_valid", int'(ack_valid), 0);
    chk("R1 disabled", int'(int_disabled), 1);
    chk("R1 nmi flag", int'(nmi_active), 0);
    chk("R1 in_service", int'(in_service), 0);
    rd_ctrl(0, rd); chk("R1 ctrl reset", int'(rd), 'h47);

    wr_ctrl(0, 8'h03); wr_ctrl(1, 8'h03); wr_ctrl(2, 8'h01); wr_ctrl(3, 8'h45);

    // R11 masked source
    pulse_ei();
    pulse_src(4'b1000);
    quiet(12, "R11 masked offered");
    rd_ctrl(3, rd); chk("R11 flag pending", int'(rd), 'hC5);
    wr_ctrl(3, 8'h05);

    // R2 latency, R5 vector, R12 hold, R4 acceptance
    pulse_src(4'b0001);
    wait_offer(n);
    chk("R2 latency", n, 8);
    chk("R5 vector src0", int'(ack_vector), 'h80);
    begin
      bit bad = 0;
      repeat (5) begin @(negedge clk); if (!ack_valid || ack_vector != 16'h80) bad = 1; end
      chk("R12 offer held", int'(bad), 0);
    end
    push_exp(16'h0080);
    accept();
    chk("R4 disabled", int'(int_disabled), 1);
    chk("R4 in_service", int'(in_service), 'h08);
    rd_ctrl(0, rd); chk("R4 flag cleared", int'(rd), 'h03);
    pulse_reti();
    chk("R10 in_service", int'(in_service), 0);
    chk("R10 enable restored", int'(int_disabled), 0);

    // R6 priority choice
    pulse_src(4'b0111);
    offer_and_take("R6 lowest prio", 8, 16'h00A0);
    chk("R4 level1", int'(in_service), 'h02);

    // R7 nesting only strictly higher
    pulse_ei();
    wr_ctrl(3, 8'h01);
    pulse_src(4'b1000);
    quiet(12, "R7 equal prio nested");
    wr_ctrl(3, 8'h80);
    offer_and_take("R7 higher nests", 8, 16'h00B0);
    chk("R7 two levels", int'(in_service), 'h03);
    pulse_reti();
    chk("R10 clears most urgent", int'(in_service), 'h02);
    chk("R10 id restore nested", int'(int_disabled), 0);
    quiet(10, "R7 lower still held");
    pulse_reti();
    chk("R10 all retired", int'(in_service), 0);
    offer_and_take("R6 tie lower index", 8, 16'h0080);
    pulse_reti();
    offer_and_take("R6 next src1", 8, 16'h0090);
    pulse_reti();

    // R3 enable window
    pulse_di();
    pulse_src(4'b0001);
    quiet(10, "R3 offered while disabled");
    pulse_ei();
    @(negedge clk); @(negedge clk);
    pulse_di();
    quiet(12, "R3 DI inside window");
    rd_ctrl(0, rd); chk("R3 still pending", int'(rd), 'h83);
    pulse_ei();
    wait_offer(n);
    chk("R3 latency after EI", n, 8);
    chk("R3 vector", int'(ack_vector), 'h80);

    // R9 rewrite in acceptance cycle
    push_exp(16'h0080);
    accept_wr(0, 8'h82);
    rd_ctrl(0, rd); chk("R9 flag cleared, prio written", int'(rd), 'h02);
    pulse_reti();
    quiet(12, "R9 serviced twice");

    // R8 non-maskable
    pulse_di();
    pulse_nmi();
    offer_and_take("R8 nmi while disabled", 8, 16'h0010);
    chk("R8 nmi flag", int'(nmi_active), 1);
    chk("R8 disabled", int'(int_disabled), 1);
    pulse_src(4'b0001);
    pulse_ei();
    pulse_nmi();
    quiet(12, "R8 held in nmi");
    pulse_reti();
    chk("R10 nmi cleared", int'(nmi_active), 0);
    chk("R10 nmi id restore", int'(int_disabled), 1);
    pulse_ei();
    offer_and_take("R6 nmi over maskable", 8, 16'h0010);
    pulse_reti();
    chk("R10 id after nmi", int'(int_disabled), 0);
    offer_and_take("R6 maskable after nmi", 8, 16'h0080);
    pulse_reti();

    chk("R5 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule